// File: doc/BRIEF.md
# PCI interrupt line router

This block steers four shared PCI interrupt request lines onto sixteen legacy interrupt controller inputs. A bank of four byte-wide steering registers, one per request line, selects which controller input each line drives. A value of 16 or more parks the line so that it drives nothing. Several request lines may share one controller input. That input is then the OR of all the lines steered to it and currently asserted.

The steering bank is written through a single-cycle write strobe that carries a dword-aligned byte address, 32 data bits and four byte enables. There is no ready signal: every strobe is taken in the cycle it is presented, so the port never applies back-pressure. A steering write takes effect at once. The level map is cleared and rebuilt from the present request levels under the new steering, so a line that is already asserted moves to its new output. Outside writes, only the map bit of the line that changed level is touched.

A small combinational helper maps a device's INTx pin onto a request line. It rotates the pin number by the device's slot number, so neighbouring slots spread their INTA pins across different lines.

Top module: `pci_irq_router`

## Requirements
- R1: While reset is asserted and after it is released, every steering register holds 0x80 (parked) and every `irq_out` bit is 0, whatever the request levels are.
- R2: A write with `cfg_wr_addr[7:2]` equal to 0x60>>2 updates the steering register of line p (0=A, 1=B, 2=C, 3=D) from data byte lane p (`cfg_wr_data[8p+7:8p]`) exactly when `cfg_wr_be[p]` is 1. Lanes whose enable is 0, and writes to any other dword address, leave the steering registers unchanged.
- R3: A steering value v below 16 steers its line to `irq_out[v]`. Any value of 16 or more (0x10 through 0xFF) parks the line, and its level then has no effect on any output.
- R4: Each `irq_out[i]` is 1 exactly when at least one asserted request line is steered to i. An output shared by two lines stays 1 until both lines deassert.
- R5: A change of `pirq_in` sampled at a rising clock edge appears on `irq_out` right after that edge and not before it.
- R6: After a steering write, `irq_out` reflects the new steering applied to the current request levels from the following edge on. A line that is asserted when rerouted leaves its old output and drives its new one. A line asserted while parked drives its output as soon as it is given a live value.
- R7: `dev_pirq` equals (`dev_intx` + `dev_devfn[7:3]` - 1) mod 4, combinationally. For example, slot 0 with INTA gives line 3.
- R8: When a steering write and a request level change fall in the same cycle, the rebuilt outputs use the request level present in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Single-cycle write strobe for the steering bank |
| cfg_wr_addr | input | 8 | Byte address of the written dword (low two bits ignored) |
| cfg_wr_data | input | 32 | Write data, byte lane k goes to address + k |
| cfg_wr_be | input | 4 | Byte enables, bit k enables lane k |
| pirq_in | input | 4 | Levels of request lines A (bit 0) to D (bit 3), active high |
| dev_devfn | input | 8 | Device/function number of the device being looked up |
| dev_intx | input | 2 | Interrupt pin of that device, 0=INTA to 3=INTD |
| dev_pirq | output | 2 | Request line the pin maps to, 0=A to 3=D |
| irq_out | output | 16 | Level-sensitive controller inputs, active high |

## Verification
The hardest state to reach is a line that is asserted while its steering value is parked. Its level never produced a map update, so only the rebuild on a later steering write can make it visible. The bench parks all lines, raises one, checks that nothing comes out, and then gives that line a live value to see the level appear. It also puts a steering write and a level change in the same cycle, to show that the rebuild takes the newest level. Byte-enable masking and the boundary values 0x0F and 0x10 are exercised with partial-lane writes on an output that is already active.

// File: rtl/pirq_rtr_pkg.sv
package pirq_rtr_pkg;

  // Default geometry of the router
  localparam int unsigned LINE_COUNT_DEF  = 4;
  localparam int unsigned IRQ_COUNT_DEF   = 16;
  localparam int unsigned STEER_W_DEF     = 8;
  localparam int unsigned ADDR_W_DEF      = 8;
  localparam int unsigned DATA_W_DEF      = 32;
  localparam int unsigned STEER_BASE_DEF  = 32'h60;
  localparam int unsigned STEER_RESET_DEF = 32'h80;
  localparam int unsigned DEVFN_W_DEF     = 8;
  localparam int unsigned FUNC_W_DEF      = 3;

  // A steering value is live when it names an existing controller input
  function automatic bit steer_live(input int unsigned value, input int unsigned n_irq);
    return value < n_irq;
  endfunction

endpackage

// File: rtl/pirq_route_bank.sv
module pirq_route_bank #(
  parameter int NUM_PIRQ    = 4,
  parameter int ROUTE_W     = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int ROUTE_BASE  = 32'h60,
  parameter int ROUTE_RESET = 32'h80,
  localparam int BE_W       = DATA_W / 8,
  localparam int LANE_W     = $clog2(BE_W)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic [BE_W-1:0]                   wr_be,
  output logic [NUM_PIRQ-1:0][ROUTE_W-1:0]  route_q,
  output logic [NUM_PIRQ-1:0][ROUTE_W-1:0]  route_nxt,
  output logic                              route_hit
);

  logic [NUM_PIRQ-1:0] lane_hit;
  logic                lane_bits_unused;

  // Byte-lane select bits of the address do not pick a register
  assign lane_bits_unused = ^wr_addr[LANE_W-1:0];

  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_reg
    localparam int BYTE_ADDR = ROUTE_BASE + p;
    localparam int LANE      = BYTE_ADDR % BE_W;
    localparam int WORD_IDX  = BYTE_ADDR / BE_W;

    // Decode: right dword, lane enabled
    assign lane_hit[p] = wr_en
                       && (wr_addr[ADDR_W-1:LANE_W] == WORD_IDX[ADDR_W-LANE_W-1:0])
                       && wr_be[LANE];

    // Value the register holds after this edge
    assign route_nxt[p] = lane_hit[p] ? wr_data[LANE*8 +: ROUTE_W] : route_q[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        route_q[p] <= ROUTE_RESET[ROUTE_W-1:0];
      end else begin
        route_q[p] <= route_nxt[p];
      end
    end
  end

  assign route_hit = |lane_hit;

endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
  import pirq_rtr_pkg::*;
#(
  parameter int NUM_PIRQ  = 4,
  parameter int NUM_IRQ   = 16,
  parameter int ROUTE_W   = 8,
  localparam int MAP_W     = NUM_PIRQ * NUM_IRQ,
  localparam int MAP_IDX_W = $clog2(MAP_W),
  localparam int IRQ_IDX_W = $clog2(NUM_IRQ)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PIRQ-1:0]               pirq_in,
  input  logic [NUM_PIRQ-1:0][ROUTE_W-1:0]  route_q,
  input  logic [NUM_PIRQ-1:0][ROUTE_W-1:0]  route_nxt,
  input  logic                              rebuild,
  output logic [MAP_W-1:0]                  map_q
);

  logic [NUM_PIRQ-1:0] pirq_q;
  logic [MAP_W-1:0]    map_d;

  // Map position of (irq, line): irq * NUM_PIRQ + line
  function automatic logic [MAP_IDX_W-1:0] map_pos(input logic [ROUTE_W-1:0] route,
                                                   input int line);
    logic [IRQ_IDX_W-1:0] irq_idx;
    irq_idx = route[IRQ_IDX_W-1:0];
    return MAP_IDX_W'(irq_idx) * MAP_IDX_W'(NUM_PIRQ) + MAP_IDX_W'(line);
  endfunction

  always_comb begin
    map_d = map_q;
    if (rebuild) begin
      // Steering changed: drop every bit and rebuild from present levels
      map_d = '0;
      for (int p = 0; p < NUM_PIRQ; p++) begin
        if (pirq_in[p] && steer_live(int'(route_nxt[p]), NUM_IRQ)) begin
          map_d[map_pos(route_nxt[p], p)] = 1'b1;
        end
      end
    end else begin
      // Level event: touch only the bit of the line that moved
      for (int p = 0; p < NUM_PIRQ; p++) begin
        if ((pirq_in[p] != pirq_q[p]) && steer_live(int'(route_q[p]), NUM_IRQ)) begin
          map_d[map_pos(route_q[p], p)] = pirq_in[p];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pirq_q <= '0;
      map_q  <= '0;
    end else begin
      pirq_q <= pirq_in;
      map_q  <= map_d;
    end
  end

endmodule

// File: rtl/pirq_irq_merge.sv
module pirq_irq_merge #(
  parameter int NUM_PIRQ = 4,
  parameter int NUM_IRQ  = 16,
  localparam int MAP_W   = NUM_PIRQ * NUM_IRQ
) (
  input  logic [MAP_W-1:0]   map_q,
  output logic [NUM_IRQ-1:0] irq_out
);

  // Each controller input collects its own group of NUM_PIRQ map bits
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    assign irq_out[i] = |map_q[i*NUM_PIRQ +: NUM_PIRQ];
  end

endmodule

// File: rtl/pirq_slot_swizzle.sv
module pirq_slot_swizzle #(
  parameter int NUM_PIRQ    = 4,
  parameter int DEVFN_W     = 8,
  parameter int FUNC_W      = 3,
  localparam int PIRQ_IDX_W = $clog2(NUM_PIRQ),
  localparam int SLOT_W     = DEVFN_W - FUNC_W
) (
  input  logic [DEVFN_W-1:0]    devfn,
  input  logic [PIRQ_IDX_W-1:0] intx,
  output logic [PIRQ_IDX_W-1:0] pirq_idx
);

  logic [SLOT_W-1:0] slot;
  logic              func_bits_unused;
  int unsigned       sum_v;

  assign slot             = devfn[DEVFN_W-1:FUNC_W];
  assign func_bits_unused = ^devfn[FUNC_W-1:0];

  // Rotate the pin by (slot - 1); NUM_PIRQ is added so the sum never goes negative
  always_comb begin
    sum_v    = int'(intx) + int'(slot) + NUM_PIRQ - 1;
    pirq_idx = PIRQ_IDX_W'(sum_v % NUM_PIRQ);
  end

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pirq_rtr_pkg::*;
#(
  parameter int NUM_PIRQ    = LINE_COUNT_DEF,
  parameter int NUM_IRQ     = IRQ_COUNT_DEF,
  parameter int ROUTE_W     = STEER_W_DEF,
  parameter int ADDR_W      = ADDR_W_DEF,
  parameter int DATA_W      = DATA_W_DEF,
  parameter int ROUTE_BASE  = STEER_BASE_DEF,
  parameter int ROUTE_RESET = STEER_RESET_DEF,
  parameter int DEVFN_W     = DEVFN_W_DEF,
  parameter int FUNC_W      = FUNC_W_DEF,
  localparam int BE_W       = DATA_W / 8,
  localparam int MAP_W      = NUM_PIRQ * NUM_IRQ,
  localparam int PIRQ_IDX_W = $clog2(NUM_PIRQ)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr_en,
  input  logic [ADDR_W-1:0]     cfg_wr_addr,
  input  logic [DATA_W-1:0]     cfg_wr_data,
  input  logic [BE_W-1:0]       cfg_wr_be,
  input  logic [NUM_PIRQ-1:0]   pirq_in,
  input  logic [DEVFN_W-1:0]    dev_devfn,
  input  logic [PIRQ_IDX_W-1:0] dev_intx,
  output logic [PIRQ_IDX_W-1:0] dev_pirq,
  output logic [NUM_IRQ-1:0]    irq_out
);

  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q;
  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_nxt;
  logic                             route_hit;
  logic [MAP_W-1:0]                 map_q;

  pirq_route_bank #(
    .NUM_PIRQ    (NUM_PIRQ),
    .ROUTE_W     (ROUTE_W),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .ROUTE_BASE  (ROUTE_BASE),
    .ROUTE_RESET (ROUTE_RESET)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_addr   (cfg_wr_addr),
    .wr_data   (cfg_wr_data),
    .wr_be     (cfg_wr_be),
    .route_q   (route_q),
    .route_nxt (route_nxt),
    .route_hit (route_hit)
  );

  pirq_level_map #(
    .NUM_PIRQ (NUM_PIRQ),
    .NUM_IRQ  (NUM_IRQ),
    .ROUTE_W  (ROUTE_W)
  ) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .pirq_in   (pirq_in),
    .route_q   (route_q),
    .route_nxt (route_nxt),
    .rebuild   (route_hit),
    .map_q     (map_q)
  );

  pirq_irq_merge #(
    .NUM_PIRQ (NUM_PIRQ),
    .NUM_IRQ  (NUM_IRQ)
  ) u_merge (
    .map_q   (map_q),
    .irq_out (irq_out)
  );

  pirq_slot_swizzle #(
    .NUM_PIRQ (NUM_PIRQ),
    .DEVFN_W  (DEVFN_W),
    .FUNC_W   (FUNC_W)
  ) u_swz (
    .devfn    (dev_devfn),
    .intx     (dev_intx),
    .pirq_idx (dev_pirq)
  );

endmodule

// File: rtl/pirq_rtr_checker.sv
module pirq_rtr_checker
  import pirq_rtr_pkg::*;
#(
  parameter int NUM_PIRQ    = 4,
  parameter int NUM_IRQ     = 16,
  parameter int ROUTE_W     = 8,
  localparam int MAP_W      = NUM_PIRQ * NUM_IRQ,
  localparam int IRQ_IDX_W  = $clog2(NUM_IRQ)
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             cfg_wr_en,
  input logic [NUM_PIRQ-1:0]              pirq_in,
  input logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q,
  input logic [MAP_W-1:0]                 map_q,
  input logic [NUM_IRQ-1:0]               irq_out
);

  logic [NUM_PIRQ-1:0] pirq_seen;
  logic [NUM_IRQ-1:0]  exp_irq;
  logic [NUM_PIRQ-1:0] line_present;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pirq_seen <= '0;
    else        pirq_seen <= pirq_in;
  end

  // Level-based view: outputs follow last sampled levels under present steering
  always_comb begin
    exp_irq = '0;
    for (int p = 0; p < NUM_PIRQ; p++) begin
      if (pirq_seen[p] && steer_live(int'(route_q[p]), NUM_IRQ)) begin
        exp_irq[route_q[p][IRQ_IDX_W-1:0]] = 1'b1;
      end
    end
  end

  always_comb begin
    line_present = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      for (int p = 0; p < NUM_PIRQ; p++) begin
        if (map_q[i*NUM_PIRQ + p]) line_present[p] = 1'b1;
      end
    end
  end

  // R4 and R6: outputs agree with the steering and levels seen at the last edge
  a_r4_irq_matches_steering: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == exp_irq);

  // R2: without a write strobe the steering bank holds
  a_r2_steer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(route_q));

  // R5: no write and no level change keeps every output steady
  a_r5_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_en && (pirq_in == pirq_seen)) |=> $stable(irq_out));

  // R3: a parked line owns no map bit
  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_park
    a_r3_parked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !steer_live(int'(route_q[p]), NUM_IRQ) |-> !line_present[p]);
  end

endmodule

bind pci_irq_router pirq_rtr_checker #(
  .NUM_PIRQ (NUM_PIRQ),
  .NUM_IRQ  (NUM_IRQ),
  .ROUTE_W  (ROUTE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr_en (cfg_wr_en),
  .pirq_in   (pirq_in),
  .route_q   (route_q),
  .map_q     (map_q),
  .irq_out   (irq_out)
);

// File: tb/tb_pci_irq_router.sv
module tb_pci_irq_router;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_addr = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [3:0]  cfg_wr_be = '0;
  logic [3:0]  pirq_in = '0;
  logic [7:0]  dev_devfn = '0;
  logic [1:0]  dev_intx = '0;
  logic [1:0]  dev_pirq;
  logic [15:0] irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  pci_irq_router dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_addr (cfg_wr_addr),
    .cfg_wr_data (cfg_wr_data),
    .cfg_wr_be   (cfg_wr_be),
    .pirq_in     (pirq_in),
    .dev_devfn   (dev_devfn),
    .dev_intx    (dev_intx),
    .dev_pirq    (dev_pirq),
    .irq_out     (irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [31:0] data;
    logic [3:0]  lines;
    logic [15:0] expect_irq;
  } vec_t;

  // Full-lane steering writes with levels applied in the same cycle (R3, R4, R6)
  localparam vec_t VECS [6] = '{
    '{32'h0B0A0905, 4'b0001, 16'h0020},
    '{32'h0B0A0905, 4'b1111, 16'h0E20},
    '{32'h03030303, 4'b0110, 16'h0008},
    '{32'h100F0080, 4'b1111, 16'h8001},
    '{32'hFF0E0D01, 4'b1010, 16'h2000},
    '{32'h07070707, 4'b0000, 16'h0000}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] data, input logic [3:0] be);
    cfg_wr_en   = 1'b1;
    cfg_wr_addr = addr;
    cfg_wr_data = data;
    cfg_wr_be   = be;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
    cfg_wr_be   = '0;
  endtask

  task automatic set_lines(input logic [3:0] v);
    pirq_in = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    pirq_in = 4'hF;
    repeat (3) @(negedge clk);
    check("R1 during reset", irq_out, 16'h0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 parked after reset", irq_out, 16'h0000);
    set_lines(4'h0);

    // Table walk
    for (int k = 0; k < 6; k++) begin
      pirq_in = VECS[k].lines;
      wr(8'h60, VECS[k].data, 4'hF);
      check($sformatf("R4 vector %0d", k), irq_out, VECS[k].expect_irq);
    end

    // R7: slot swizzle
    dev_devfn = 8'h08; dev_intx = 2'd0; #1;
    check("R7 slot1 INTA", {14'b0, dev_pirq}, 16'd0);
    dev_devfn = 8'h10; dev_intx = 2'd3; #1;
    check("R7 slot2 INTD", {14'b0, dev_pirq}, 16'd0);
    dev_devfn = 8'h00; dev_intx = 2'd0; #1;
    check("R7 slot0 INTA", {14'b0, dev_pirq}, 16'd3);
    dev_devfn = 8'h1F; dev_intx = 2'd1; #1;
    check("R7 slot3 func7 INTB", {14'b0, dev_pirq}, 16'd3);
    @(negedge clk);

    // A and C share output 7
    wr(8'h60, 32'h80078007, 4'hF);
    check("R4 idle shared", irq_out, 16'h0000);
    pirq_in = 4'b0001;
    #1;
    check("R5 before edge", irq_out, 16'h0000);
    @(negedge clk);
    check("R5 after edge", irq_out, 16'h0080);
    set_lines(4'b0101);
    check("R4 both asserted", irq_out, 16'h0080);
    set_lines(4'b0100);
    check("R4 one still held", irq_out, 16'h0080);
    set_lines(4'b0000);
    check("R4 both released", irq_out, 16'h0000);
    set_lines(4'b0001);

    // R6: reroute an asserted line
    wr(8'h60, 32'h00000002, 4'b0001);
    check("R6 reroute moves level", irq_out, 16'h0004);

    // R2: ignored writes and lane masking
    wr(8'h60, 32'h09090909, 4'b0000);
    check("R2 no lane enabled", irq_out, 16'h0004);
    wr(8'h64, 32'h00000000, 4'hF);
    check("R2 other address", irq_out, 16'h0004);
    wr(8'h60, 32'h05050505, 4'b1110);
    check("R2 lane0 masked", irq_out, 16'h0004);
    set_lines(4'b1001);
    check("R2 lane3 written", irq_out, 16'h0024);

    // R3: boundary values
    wr(8'h60, 32'h00000010, 4'b0001);
    check("R3 value 0x10 parks", irq_out, 16'h0020);
    wr(8'h60, 32'h0000000F, 4'b0001);
    check("R3 value 0x0F live", irq_out, 16'h8020);

    // Asserted while parked, then given a live value
    set_lines(4'b0000);
    wr(8'h60, 32'h80808080, 4'hF);
    set_lines(4'b0010);
    check("R3 parked asserted line", irq_out, 16'h0000);
    wr(8'h60, 32'h00000C00, 4'b0010);
    check("R6 parked line enabled", irq_out, 16'h1000);

    // R8: write and level change in one cycle
    pirq_in = 4'b0000;
    wr(8'h60, 32'h00000400, 4'b0010);
    check("R8 write with drop", irq_out, 16'h0000);
    pirq_in = 4'b0001;
    wr(8'h60, 32'h00000006, 4'b0001);
    check("R8 write with rise", irq_out, 16'h0040);

    // R1: reset in mid-run restores parked steering
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 mid-run reset", irq_out, 16'h0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 line parked after reset", irq_out, 16'h0000);
    wr(8'h60, 32'h00000001, 4'b0001);
    check("R1 rebuild after reset", irq_out, 16'h0002);
    set_lines(4'b0011);
    check("R1 line B back to parked", irq_out, 16'h0002);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule